// File: doc/BRIEF.md
# EDID Display Mode Controller

This block runs on the display side of an EDID link and chooses between two modes. In the streaming mode (DDC1), it sends the EDID image out on SDA without being asked. It sends one bit for each rising edge of a vertical-sync-derived clock (VCLK). In the addressed mode (DDC2), it stops sending and leaves SDA to an external two-wire slave.

The block synchronises its SCL and VCLK inputs and acts on their edges in the system clock domain. A falling SCL edge while streaming moves the block into a transition state. In that state a watchdog counts VCLK edges. The watchdog sends the block back to streaming if no valid DDC2 address arrives in time. Every falling SCL edge restarts the watchdog. Once a valid address strobe arrives, the block stays in DDC2 for good.

The EDID bytes come from an external array through a byte read port. SDA is driven open-drain through a single output enable.

Top module: `edid_mode_ctrl`

## Requirements
- R1: After reset, `mode_ddc2` is 0, `sda_oe` is 0 and `rd_addr` is 0. Until the first VCLK rising edge, the block stays idle with SDA released, whatever SCL does.
- R2: `scl_in` and `vclk_in` pass through SYNC_STAGES flip-flops before edge detection. A level that the clock samples at edge k takes effect on the outputs at edge k+SYNC_STAGES.
- R3: The first VCLK rising edge in idle starts streaming at byte address 0, with SDA still released. Each later VCLK rising edge emits one slot of the current byte, in this order: data bit DATA_W-1 down to bit 0, then one released slot. `sda_oe` is 1 exactly when the emitted data bit is 0.
- R4: After the released slot, `rd_addr` steps up by one and wraps from 2^ADDR_W-1 to 0.
- R5: A falling SCL edge while streaming sets `mode_ddc2` to 1 and `sda_oe` to 0 on the same update. If a VCLK rising edge lands in the same cycle, the SCL edge wins, and the VCLK edge emits no slot and does not advance the address.
- R6: In the transition state, WDOG_LIMIT VCLK rising edges with no falling SCL edge and no address strobe between them return the block to streaming. On that return, `mode_ddc2` is 0, `rd_addr` is 0 and SDA is released.
- R7: A falling SCL edge in the transition state restarts the watchdog. After it, a full WDOG_LIMIT further VCLK rising edges are needed before the block falls back.
- R8: `addr_ok` high in the transition state moves the block to DDC2 permanently. After that, `mode_ddc2` stays 1 and `sda_oe` stays 0 for any VCLK or SCL activity.
- R9: `addr_ok` has no effect while idle or streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw two-wire clock line level |
| vclk_in | input | 1 | Raw vertical-sync-derived bit clock |
| addr_ok | input | 1 | Strobe from the DDC2 slave decoder: a valid address was seen (system clock domain) |
| rd_data | input | DATA_W | Byte read from the EDID array at `rd_addr` |
| rd_addr | output | ADDR_W | Byte address of the byte being streamed |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| mode_ddc2 | output | 1 | Current mode: 0 for DDC1 (idle or streaming), 1 for DDC2 (transition or addressed) |

## Verification
The bench builds the block with ADDR_W=3, DATA_W=8, WDOG_LIMIT=8 and SYNC_STAGES=2. With an eight-byte image, the address wraps after 72 VCLK edges, so the wrap and the next byte's first bit fall inside a short run. A watchdog limit of 8 makes fallback, and restarting the watchdog with SCL, cheap to hit at the exact edge. Two synchroniser stages keep the latency window short enough to probe the cycle before and the cycle of each SCL-driven change.

// File: rtl/edid_mode_pkg.sv
package edid_mode_pkg;
  // Bit 1 of the encoding is the reported mode (0 = DDC1, 1 = DDC2).
  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,
    MS_STREAM = 2'd1,
    MS_XWAIT  = 2'd2,
    MS_DDC2   = 2'd3
  } mode_state_e;
endpackage

// File: rtl/ddc_edge_sync.sv
module ddc_edge_sync #(
  parameter int STAGES    = 2,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_pulse
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic              lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) sh[i] <= sh[i-1];
      sh[0] <= din;
      prev  <= sh[STAGES-1];
    end
  end

  assign lvl = sh[STAGES-1];

  generate
    if (FALL_EDGE) begin : g_fall
      assign edge_pulse = prev & ~lvl;
    end else begin : g_rise
      assign edge_pulse = lvl & ~prev;
    end
  endgenerate

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> !edge_pulse); // R2
endmodule

// File: rtl/ddc1_streamer.sv
module ddc1_streamer #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sda_oe
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_SLOT = BIT_W'(DATA_W);

  logic [BIT_W-1:0] slot_q;
  logic [IDX_W-1:0] idx;

  assign idx = IDX_W'(DATA_W - 1) - slot_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      rd_addr <= '0;
      slot_q  <= '0;
      sda_oe  <= 1'b0;
    end else if (!run) begin
      sda_oe <= 1'b0;
    end else if (bit_tick) begin
      if (slot_q == LAST_SLOT) begin
        sda_oe  <= 1'b0;
        slot_q  <= '0;
        rd_addr <= rd_addr + 1'b1;
      end else begin
        sda_oe <= ~rd_data[idx];
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST_SLOT); // R3
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> (rd_addr == $past(rd_addr) && !sda_oe)); // R5
endmodule

// File: rtl/xfer_watchdog.sv
module xfer_watchdog #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic at_last
);
  localparam int CNT_W = $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign at_last = (cnt_q == LAST);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> !at_last); // R7
endmodule

// File: rtl/edid_mode_ctrl.sv
module edid_mode_ctrl
  import edid_mode_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int WDOG_LIMIT  = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              vclk_in,
  input  logic              addr_ok,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sda_oe,
  output logic              mode_ddc2
);
  mode_state_e st_q, st_d;
  logic scl_fall, vclk_rise;
  logic restart, run, wd_clear, wd_tick, wd_last;

  ddc_edge_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_in), .edge_pulse(scl_fall)
  );

  ddc_edge_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_vclk_sync (
    .clk(clk), .rst(rst), .din(vclk_in), .edge_pulse(vclk_rise)
  );

  always_comb begin
    st_d     = st_q;
    restart  = 1'b0;
    wd_clear = 1'b0;
    wd_tick  = 1'b0;
    unique case (st_q)
      MS_IDLE: begin
        if (vclk_rise) begin
          st_d    = MS_STREAM;
          restart = 1'b1;
        end
      end
      MS_STREAM: begin
        if (scl_fall) begin
          st_d     = MS_XWAIT;
          wd_clear = 1'b1;
        end
      end
      MS_XWAIT: begin
        if (addr_ok) begin
          st_d = MS_DDC2;
        end else if (scl_fall) begin
          wd_clear = 1'b1;
        end else if (vclk_rise) begin
          wd_tick = 1'b1;
          if (wd_last) begin
            st_d    = MS_STREAM;
            restart = 1'b1;
          end
        end
      end
      default: st_d = MS_DDC2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= MS_IDLE;
    else     st_q <= st_d;
  end

  assign run       = (st_q == MS_STREAM) && !scl_fall;
  assign mode_ddc2 = st_q[1];

  xfer_watchdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk(clk), .rst(rst), .clear(wd_clear), .tick(wd_tick), .at_last(wd_last)
  );

  ddc1_streamer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stream (
    .clk(clk), .rst(rst), .restart(restart), .run(run), .bit_tick(vclk_rise),
    .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_IDLE) |-> !sda_oe); // R1
  AST_FALL_EXITS: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_STREAM && scl_fall) |=> (mode_ddc2 && !sda_oe)); // R5
  AST_FALLBACK_START: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_XWAIT && st_d == MS_STREAM) |=> (rd_addr == '0 && !sda_oe)); // R6
  AST_DDC2_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    mode_ddc2 |-> !sda_oe); // R8
  AST_DDC2_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st_q == MS_DDC2) |=> (st_q == MS_DDC2)); // R8
  AST_STRB_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!mode_ddc2 && addr_ok && !scl_fall) |=> !mode_ddc2); // R9
endmodule

// File: tb/sim_edid_mode_ctrl.sv
module sim_edid_mode_ctrl;
  localparam int AW = 3, DW = 8, WL = 8, SS = 2;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b0, vclk = 1'b0, aok = 1'b0;
  logic [DW-1:0] rdat;
  logic [AW-1:0] raddr;
  logic oe, mode;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] rom(input logic [AW-1:0] a);
    logic [7:0] x;
    x = {5'b0, a};
    return DW'((x * 8'd53 + 8'd17) ^ (x << 4));
  endfunction

  assign rdat = rom(raddr);

  edid_mode_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WDOG_LIMIT(WL), .SYNC_STAGES(SS)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .vclk_in(vclk), .addr_ok(aok),
    .rd_data(rdat), .rd_addr(raddr), .sda_oe(oe), .mode_ddc2(mode)
  );

  // Behavioural reference: 0 idle, 1 streaming, 2 transition, 3 addressed
  int ms, ma, mb, mo, mc;
  int hs[SS+2];
  int hv[SS+2];
  bit vr, sf;
  logic [DW-1:0] mbyte;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; ma = 0; mb = 0; mo = 0; mc = 0;
      for (int i = 0; i < SS + 2; i++) begin hs[i] = 0; hv[i] = 0; end
    end else begin
      for (int i = SS + 1; i > 0; i--) begin hs[i] = hs[i-1]; hv[i] = hv[i-1]; end
      hs[0] = int'(scl); hv[0] = int'(vclk);
      vr = (hv[SS] == 1) && (hv[SS+1] == 0);
      sf = (hs[SS] == 0) && (hs[SS+1] == 1);
      case (ms)
        0: if (vr) begin ms = 1; ma = 0; mb = 0; mo = 0; end
        1: begin
          if (sf) begin ms = 2; mc = 0; mo = 0; end
          else if (vr) begin
            if (mb < DW) begin
              mbyte = rom(AW'(ma));
              mo = mbyte[DW-1-mb] ? 0 : 1;
              mb++;
            end else begin
              mo = 0; mb = 0; ma = (ma + 1) % (1 << AW);
            end
          end
        end
        2: begin
          if (aok) ms = 3;
          else if (sf) mc = 0;
          else if (vr) begin
            if (mc == WL - 1) begin ms = 1; ma = 0; mb = 0; mo = 0; end
            else mc++;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R5 mode vs model", int'(mode), (ms >= 2) ? 1 : 0);
      chk("R3 sda_oe vs model", int'(oe), mo);
      chk("R4 rd_addr vs model", int'(raddr), ma);
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vpulse(input int n);
    for (int i = 0; i < n; i++) begin
      vclk = 1'b1; waitn(3);
      vclk = 1'b0; waitn(3);
    end
  endtask

  task automatic scl_drop();
    scl = 1'b0; waitn(4);
    scl = 1'b1; waitn(4);
  endtask

  initial begin
    logic [DW-1:0] b0;
    waitn(4);
    rst = 1'b0;
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset sda_oe", int'(oe), 0);
    chk("R1 reset rd_addr", int'(raddr), 0);

    // Idle: SCL activity and strobe do nothing
    scl = 1'b1; waitn(4); scl = 1'b0; waitn(4);
    aok = 1'b1; waitn(1); aok = 1'b0;
    scl = 1'b1; waitn(4);
    chk("R1 idle sda released", int'(oe), 0);
    chk("R9 idle strobe ignored", int'(mode), 0);

    // Enter streaming, then first bit of byte 0
    vpulse(1);
    chk("R3 entry released", int'(oe), 0);
    vpulse(1);
    b0 = rom('0);
    chk("R3 first bit MSB", int'(oe), b0[DW-1] ? 0 : 1);
    vpulse(7);
    vpulse(1);
    chk("R3 ninth slot released", int'(oe), 0);
    chk("R4 address stepped", int'(raddr), 1);
    vpulse(9 * 7);
    chk("R4 address wrapped", int'(raddr), 0);
    aok = 1'b1; waitn(1); aok = 1'b0; waitn(3);
    chk("R9 stream strobe ignored", int'(mode), 0);

    // SCL fall latency and exit
    vpulse(2);
    scl = 1'b0;
    waitn(2);
    chk("R2 fall not yet acted", int'(mode), 0);
    waitn(1);
    chk("R2 fall acted", int'(mode), 1);
    chk("R5 SDA released on exit", int'(oe), 0);
    waitn(3); scl = 1'b1; waitn(4);

    // Watchdog restart and fallback
    vpulse(5);
    scl_drop();
    vpulse(WL - 1);
    chk("R7 restarted watchdog holds", int'(mode), 1);
    vpulse(1);
    chk("R6 fallback mode", int'(mode), 0);
    chk("R6 fallback address", int'(raddr), 0);
    chk("R6 fallback released", int'(oe), 0);

    // Simultaneous SCL fall and VCLK rise
    vpulse(DW + 1);
    scl = 1'b0; vclk = 1'b1;
    waitn(4);
    chk("R5 SCL wins mode", int'(mode), 1);
    chk("R5 SCL wins sda", int'(oe), 0);
    chk("R5 no address step", int'(raddr), 1);
    vclk = 1'b0; waitn(3); scl = 1'b1; waitn(4);

    // Valid address ends transition permanently
    vpulse(3);
    aok = 1'b1; waitn(1); aok = 1'b0; waitn(2);
    chk("R8 address accepted", int'(mode), 1);
    scl_drop();
    vpulse(3 * WL);
    chk("R8 stays DDC2", int'(mode), 1);
    chk("R8 SDA never driven", int'(oe), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule